// File: doc/BRIEF.md
# Copy-Protection Pseudo-Sync Pulse Detector

The block watches a digitised composite sync stream, together with separate horizontal and vertical sync inputs, for the narrow extra sync pulses that analog copy protection places in the vertical blanking interval. It measures every low-going excursion of the sync level in pixel clocks. A pulse counts as a candidate only if its width lies within a programmable minimum/maximum band. When the input is sampled at twice the nominal rate, the measured width is halved before that comparison. Only pulses on lines inside a programmable line window are counted.

Once per field, at the horizontal sync that ends the last window line, the block decides whether protection is present. In standard-definition mode the decision uses only the pulses in the final three window lines. In progressive mode it uses the whole window. The decision compares that count against one of four selectable thresholds. The detect flag and the total count of accepted window pulses are then held until the next field's decision. An override input chooses between the programmable width and line settings and built-in presets. The presets depend on the line standard.

Top module: `cp_pulse_detect`

## Requirements
- R1: A closed low pulse whose compared width w satisfies wmin <= w <= wmax is accepted, and any other pulse is discarded. The width is the number of rising clock edges at which sync_lvl was sampled 0.
- R2: With cfg_ovr = 0 the settings are fixed: width band 6..9 for both standards, line window 13..21 when pal_mode = 0 and 8..16 when pal_mode = 1. With cfg_ovr = 1 the cfg_* inputs are used.
- R3: The line number becomes 0 on the rising edge of vsync and increments on each rising edge of hsync, so the first line after vsync is line 1. A pulse counts only if its line n satisfies start <= n <= end.
- R4: With ovs_en = 1 the measured width is halved (rounded down) before the R1 comparison. With ovs_en = 0 it is used unchanged.
- R5: cfg_need_sel selects the required pulse count: 2'b00 = 6, 2'b01 = 4, 2'b10 = 5, 2'b11 = 7.
- R6: With prog_mode = 0, detect is set only if at least the required count of accepted pulses lies on window lines n with n + 2 >= end.
- R7: With prog_mode = 1, detect is set if at least the required count of accepted pulses lies anywhere in the window.
- R8: detect and pulse_cnt change only at the rising hsync edge that ends line `end`, and hold until the next field's evaluation. pulse_cnt is the number of accepted window pulses in that field. A pulse whose sync_lvl returns high one clock before that hsync edge is included.
- R9: A pulse that is still low when an hsync or vsync rising edge arrives is discarded.
- R10: After reset, detect is 0 and pulse_cnt is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync | input | 1 | Horizontal sync, active high |
| vsync | input | 1 | Vertical sync, active high |
| sync_lvl | input | 1 | Sliced sync level, 0 = sync tip |
| pal_mode | input | 1 | 1 = 625-line presets, 0 = 525-line presets |
| prog_mode | input | 1 | 1 = progressive rule (R7), 0 = standard-definition rule (R6) |
| ovs_en | input | 1 | Double-rate sampling correction |
| cfg_ovr | input | 1 | 1 = use cfg_* settings, 0 = presets |
| cfg_wmin | input | 4 | Programmable minimum width |
| cfg_wmax | input | 4 | Programmable maximum width |
| cfg_start | input | 6 | Programmable first window line |
| cfg_end | input | 6 | Programmable last window line |
| cfg_need_sel | input | 2 | Required pulse count select |
| detect | output | 1 | Protection detected in the last evaluated field |
| pulse_cnt | output | 8 | Accepted window pulses in the last evaluated field |

## Verification
Two events can fall in the same clock: the acceptance strobe of a pulse that has just closed, and the field evaluation triggered by the hsync edge that ends the last window line. The bench provokes this by raising sync_lvl on the last window line exactly one clock before that hsync edge. The pulse is then the one that tips the count over the threshold, so the detect value and pulse_cnt show whether it was included. A contrasting field leaves the same pulse open across the hsync edge, and there the pulse must be dropped.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
  localparam int SET_W  = 4;
  localparam int LINE_W = 6;
  localparam int NEED_W = 3;

  typedef struct packed {
    logic [SET_W-1:0]  wmin;
    logic [SET_W-1:0]  wmax;
    logic [LINE_W-1:0] lstart;
    logic [LINE_W-1:0] lend;
  } cpd_win_t;

  // Required pulse count for each select code.
  function automatic logic [NEED_W-1:0] need_count(input logic [1:0] sel);
    logic [NEED_W-1:0] n;
    case (sel)
      2'b00:   n = 3'd6;
      2'b01:   n = 3'd4;
      2'b10:   n = 3'd5;
      default: n = 3'd7;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/cpd_rst_sync.sv
module cpd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/cpd_line_trk.sv
module cpd_line_trk
  import cpd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync,
  input  logic              vsync,
  input  logic [LINE_W-1:0] lstart,
  input  logic [LINE_W-1:0] lend,
  output logic              hs_lead,
  output logic              vs_lead,
  output logic              in_win,
  output logic              in_last3,
  output logic              at_end
);
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic              hs_q, vs_q;
  logic [LINE_W-1:0] line_cnt, line_nxt;
  logic              line_en;
  logic [LINE_W:0]   line_p2;

  assign hs_lead = hsync & ~hs_q;
  assign vs_lead = vsync & ~vs_q;
  assign line_en = hs_lead | vs_lead;

  always_comb begin
    line_nxt = line_cnt;
    if (vs_lead)
      line_nxt = '0;
    else if (hs_lead && (line_cnt != LINE_MAX))
      line_nxt = line_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q     <= 1'b0;
      vs_q     <= 1'b0;
      line_cnt <= '0;
    end else begin
      hs_q <= hsync;
      vs_q <= vsync;
      if (line_en)
        line_cnt <= line_nxt;
    end
  end

  assign line_p2  = {1'b0, line_cnt} + (LINE_W+1)'(2);
  assign in_win   = (line_cnt >= lstart) && (line_cnt <= lend);
  assign in_last3 = in_win && (line_p2 >= {1'b0, lend});
  assign at_end   = (line_cnt == lend);

  // R3
  vs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vs_lead |=> (line_cnt == '0));

  // R3
  hs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_lead && !vs_lead && (line_cnt != LINE_MAX)) |=> (line_cnt == $past(line_cnt) + 1'b1));
endmodule

// File: rtl/cpd_width_meas.sv
module cpd_width_meas
  import cpd_pkg::*;
#(
  parameter int MEAS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_lvl,
  input  logic             abort,
  input  logic             in_win,
  input  logic             in_last3,
  input  logic             ovs_en,
  input  logic [SET_W-1:0] wmin,
  input  logic [SET_W-1:0] wmax,
  output logic             acc_win,
  output logic             acc_last3
);
  localparam logic [MEAS_W-1:0] MEAS_MAX = '1;

  logic              sync_q, active_q, active_nxt;
  logic [MEAS_W-1:0] wcnt_q, wcnt_nxt, scaled;
  logic              acc_win_nxt, acc_l3_nxt, width_ok;
  logic              fall, closing;

  assign fall    = sync_q & ~sync_lvl;
  assign closing = active_q & sync_lvl;
  assign scaled  = ovs_en ? (wcnt_q >> 1) : wcnt_q;
  assign width_ok = (scaled >= MEAS_W'(wmin)) && (scaled <= MEAS_W'(wmax));

  always_comb begin
    active_nxt  = active_q;
    wcnt_nxt    = wcnt_q;
    acc_win_nxt = 1'b0;
    acc_l3_nxt  = 1'b0;
    if (abort) begin
      active_nxt = 1'b0;
      wcnt_nxt   = '0;
    end else if (fall) begin
      active_nxt = 1'b1;
      wcnt_nxt   = MEAS_W'(1);
    end else if (active_q && !sync_lvl) begin
      if (wcnt_q != MEAS_MAX)
        wcnt_nxt = wcnt_q + 1'b1;
    end else if (closing) begin
      active_nxt  = 1'b0;
      acc_win_nxt = width_ok & in_win;
      acc_l3_nxt  = width_ok & in_last3;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= 1'b1;
      active_q  <= 1'b0;
      wcnt_q    <= '0;
      acc_win   <= 1'b0;
      acc_last3 <= 1'b0;
    end else begin
      sync_q    <= sync_lvl;
      active_q  <= active_nxt;
      wcnt_q    <= wcnt_nxt;
      acc_win   <= acc_win_nxt;
      acc_last3 <= acc_l3_nxt;
    end
  end

  // R9
  open_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!acc_win && !acc_last3));

  // R6
  last3_in_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_last3 |-> acc_win);

  // R1
  closed_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_win |-> $past(sync_lvl));
endmodule

// File: rtl/cpd_field_eval.sv
module cpd_field_eval
  import cpd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_lead,
  input  logic             vs_lead,
  input  logic             at_end,
  input  logic             prog_mode,
  input  logic [1:0]       need_sel,
  input  logic             acc_win,
  input  logic             acc_last3,
  output logic             detect,
  output logic [CNT_W-1:0] pulse_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] tot_q, tot_inc, tot_nxt;
  logic [CNT_W-1:0] l3_q, l3_inc, l3_nxt;
  logic             done_q, done_nxt, eval_stb;
  logic             det_nxt;
  logic [CNT_W-1:0] pcnt_nxt, need;

  assign need     = CNT_W'(need_count(need_sel));
  assign tot_inc  = (acc_win && (tot_q != CNT_MAX)) ? tot_q + 1'b1 : tot_q;
  assign l3_inc   = (acc_last3 && (l3_q != CNT_MAX)) ? l3_q + 1'b1 : l3_q;
  assign eval_stb = hs_lead & at_end & ~vs_lead & ~done_q;

  always_comb begin
    tot_nxt  = tot_inc;
    l3_nxt   = l3_inc;
    done_nxt = done_q;
    det_nxt  = detect;
    pcnt_nxt = pulse_cnt;
    if (vs_lead) begin
      tot_nxt  = '0;
      l3_nxt   = '0;
      done_nxt = 1'b0;
    end else if (eval_stb) begin
      done_nxt = 1'b1;
      det_nxt  = prog_mode ? (tot_inc >= need) : (l3_inc >= need);
      pcnt_nxt = tot_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tot_q     <= '0;
      l3_q      <= '0;
      done_q    <= 1'b0;
      detect    <= 1'b0;
      pulse_cnt <= '0;
    end else begin
      tot_q  <= tot_nxt;
      l3_q   <= l3_nxt;
      done_q <= done_nxt;
      if (eval_stb) begin
        detect    <= det_nxt;
        pulse_cnt <= pcnt_nxt;
      end
    end
  end

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_stb |=> ($stable(detect) && $stable(pulse_cnt)));

  // R6
  l3_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l3_q <= tot_q);
endmodule

// File: rtl/cp_pulse_detect.sv
module cp_pulse_detect
  import cpd_pkg::*;
#(
  parameter int MEAS_W       = 8,
  parameter int CNT_W        = 8,
  parameter int P_WMIN       = 6,
  parameter int P_WMAX       = 9,
  parameter int P_NTSC_START = 13,
  parameter int P_NTSC_END   = 21,
  parameter int P_PAL_START  = 8,
  parameter int P_PAL_END    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync,
  input  logic              vsync,
  input  logic              sync_lvl,
  input  logic              pal_mode,
  input  logic              prog_mode,
  input  logic              ovs_en,
  input  logic              cfg_ovr,
  input  logic [3:0]        cfg_wmin,
  input  logic [3:0]        cfg_wmax,
  input  logic [5:0]        cfg_start,
  input  logic [5:0]        cfg_end,
  input  logic [1:0]        cfg_need_sel,
  output logic              detect,
  output logic [CNT_W-1:0]  pulse_cnt
);
  logic     rst_s_n;
  cpd_win_t win;
  logic     hs_lead, vs_lead, in_win, in_last3, at_end;
  logic     acc_win, acc_last3;

  always_comb begin
    if (cfg_ovr) begin
      win.wmin   = cfg_wmin;
      win.wmax   = cfg_wmax;
      win.lstart = cfg_start;
      win.lend   = cfg_end;
    end else begin
      win.wmin   = SET_W'(P_WMIN);
      win.wmax   = SET_W'(P_WMAX);
      win.lstart = pal_mode ? LINE_W'(P_PAL_START) : LINE_W'(P_NTSC_START);
      win.lend   = pal_mode ? LINE_W'(P_PAL_END)   : LINE_W'(P_NTSC_END);
    end
  end

  cpd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  cpd_line_trk u_line (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .hsync    (hsync),
    .vsync    (vsync),
    .lstart   (win.lstart),
    .lend     (win.lend),
    .hs_lead  (hs_lead),
    .vs_lead  (vs_lead),
    .in_win   (in_win),
    .in_last3 (in_last3),
    .at_end   (at_end)
  );

  cpd_width_meas #(.MEAS_W(MEAS_W)) u_meas (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .sync_lvl  (sync_lvl),
    .abort     (hs_lead | vs_lead),
    .in_win    (in_win),
    .in_last3  (in_last3),
    .ovs_en    (ovs_en),
    .wmin      (win.wmin),
    .wmax      (win.wmax),
    .acc_win   (acc_win),
    .acc_last3 (acc_last3)
  );

  cpd_field_eval #(.CNT_W(CNT_W)) u_eval (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .hs_lead   (hs_lead),
    .vs_lead   (vs_lead),
    .at_end    (at_end),
    .prog_mode (prog_mode),
    .need_sel  (cfg_need_sel),
    .acc_win   (acc_win),
    .acc_last3 (acc_last3),
    .detect    (detect),
    .pulse_cnt (pulse_cnt)
  );

  // R10
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(rst_s_n) |-> (!detect && (pulse_cnt == '0)));
endmodule

// File: tb/cp_pulse_detect_test.sv
module cp_pulse_detect_test;
  logic       clk = 1'b0;
  logic       rst_n, hsync, vsync, sync_lvl;
  logic       pal_mode, prog_mode, ovs_en, cfg_ovr;
  logic [3:0] cfg_wmin, cfg_wmax;
  logic [5:0] cfg_start, cfg_end;
  logic [1:0] cfg_need_sel;
  logic       detect;
  logic [7:0] pulse_cnt;

  int total = 0;
  int bad   = 0;
  int np  [64];
  int wid [64][8];
  bit opn [64];
  bit tgt [64];
  int prev_det = 0;
  int prev_cnt = 0;

  always #5 clk = ~clk;

  cp_pulse_detect uut (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .sync_lvl(sync_lvl),
    .pal_mode(pal_mode), .prog_mode(prog_mode), .ovs_en(ovs_en), .cfg_ovr(cfg_ovr),
    .cfg_wmin(cfg_wmin), .cfg_wmax(cfg_wmax), .cfg_start(cfg_start), .cfg_end(cfg_end),
    .cfg_need_sel(cfg_need_sel), .detect(detect), .pulse_cnt(pulse_cnt)
  );

  function automatic int need_of(input logic [1:0] s);
    case (s)
      2'b00:   return 6;
      2'b01:   return 4;
      2'b10:   return 5;
      default: return 7;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_field();
    for (int l = 0; l < 64; l++) begin
      np[l] = 0; opn[l] = 1'b0; tgt[l] = 1'b0;
      for (int k = 0; k < 8; k++) wid[l][k] = 0;
    end
  endtask

  task automatic add_pulse(input int l, input int w);
    wid[l][np[l]] = w;
    np[l]++;
  endtask

  task automatic hs_pulse();
    @(negedge clk) hsync = 1'b1;
    @(negedge clk) begin hsync = 1'b0; sync_lvl = 1'b1; end
  endtask

  task automatic run_field(input string tag);
    int es, ee, emin, emax, need, tot, l3, s;
    int exp_det;
    es   = cfg_ovr ? int'(cfg_start) : (pal_mode ? 8 : 13);
    ee   = cfg_ovr ? int'(cfg_end)   : (pal_mode ? 16 : 21);
    emin = cfg_ovr ? int'(cfg_wmin)  : 6;
    emax = cfg_ovr ? int'(cfg_wmax)  : 9;
    need = need_of(cfg_need_sel);
    @(negedge clk) vsync = 1'b1;
    @(negedge clk) vsync = 1'b0;
    // R8: results from the previous field hold across the new vsync
    check({tag, " R8 hold detect"}, int'(detect), prev_det);
    check({tag, " R8 hold pulse_cnt"}, int'(pulse_cnt), prev_cnt);
    for (int l = 0; l <= ee; l++) begin
      if (l > 0) hs_pulse();
      for (int k = 0; k < np[l]; k++) begin
        repeat (2) @(negedge clk);
        sync_lvl = 1'b0;
        repeat (wid[l][k]) @(negedge clk);
        if (!(opn[l] && k == np[l] - 1)) sync_lvl = 1'b1;
      end
      if (!(tgt[l] && np[l] > 0 && !opn[l])) repeat (3) @(negedge clk);
    end
    hs_pulse();
    repeat (3) @(negedge clk);
    tot = 0; l3 = 0;
    for (int l = 0; l <= ee; l++) begin
      for (int k = 0; k < np[l]; k++) begin
        if (opn[l] && k == np[l] - 1) continue;
        s = ovs_en ? wid[l][k] / 2 : wid[l][k];
        if (s >= emin && s <= emax && l >= es && l <= ee) begin
          tot++;
          if (l + 2 >= ee) l3++;
        end
      end
    end
    if (tot > 255) tot = 255;
    exp_det = ((prog_mode ? tot : l3) >= need) ? 1 : 0;
    check({tag, " detect"}, int'(detect), exp_det);
    check({tag, " pulse_cnt"}, int'(pulse_cnt), tot);
    prev_det = exp_det;
    prev_cnt = tot;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int dummy;
    dummy = $urandom(32'h5eed_1234);
    rst_n = 1'b0; hsync = 1'b0; vsync = 1'b0; sync_lvl = 1'b1;
    pal_mode = 1'b0; prog_mode = 1'b0; ovs_en = 1'b0; cfg_ovr = 1'b0;
    cfg_wmin = 4'd3; cfg_wmax = 4'd5; cfg_start = 6'd2; cfg_end = 6'd6;
    cfg_need_sel = 2'b10;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 reset detect", int'(detect), 0);
    check("R10 reset pulse_cnt", int'(pulse_cnt), 0);

    // R1 R2: 525-line presets, widths around the band edges, one pulse before the window
    clear_field();
    add_pulse(20, 5); add_pulse(20, 6); add_pulse(20, 9); add_pulse(20, 10);
    add_pulse(21, 6); add_pulse(21, 7); add_pulse(21, 8);
    add_pulse(19, 6); add_pulse(19, 6); add_pulse(12, 7);
    run_field("R1 R2 ntsc presets");

    // R2: 625-line presets
    pal_mode = 1'b1;
    clear_field();
    add_pulse(16, 7); add_pulse(16, 7); add_pulse(16, 7);
    add_pulse(15, 7); add_pulse(15, 7); add_pulse(7, 7); add_pulse(17, 7);
    run_field("R2 pal presets");
    pal_mode = 1'b0;

    // R4: oversampled widths, halved before comparison
    ovs_en = 1'b1;
    clear_field();
    add_pulse(21, 11); add_pulse(21, 12); add_pulse(21, 19); add_pulse(21, 20);
    add_pulse(21, 13); add_pulse(20, 18); add_pulse(20, 14);
    run_field("R4 oversample");
    ovs_en = 1'b0;

    // R5: each select code, at and one below its threshold
    cfg_ovr = 1'b1; cfg_start = 6'd3; cfg_end = 6'd6; cfg_wmin = 4'd3; cfg_wmax = 4'd5;
    for (int s = 0; s < 4; s++) begin
      cfg_need_sel = 2'(s);
      for (int m = 0; m < 2; m++) begin
        clear_field();
        for (int k = 0; k < need_of(2'(s)) - m; k++) add_pulse(6, 4);
        run_field("R5 select");
      end
    end

    // R6 R7: pulses only early in the window
    cfg_start = 6'd2; cfg_end = 6'd12; cfg_need_sel = 2'b11;
    for (int p = 0; p < 2; p++) begin
      prog_mode = 1'(p);
      clear_field();
      for (int l = 2; l <= 5; l++) begin add_pulse(l, 4); add_pulse(l, 4); end
      run_field(p ? "R7 progressive" : "R6 last three lines");
    end
    prog_mode = 1'b0;

    // R8: closing pulse one clock before the evaluating hsync edge
    cfg_start = 6'd2; cfg_end = 6'd5; cfg_need_sel = 2'b01;
    clear_field();
    add_pulse(4, 4); add_pulse(4, 4); add_pulse(4, 4); add_pulse(5, 4); tgt[5] = 1'b1;
    run_field("R8 same-cycle close");

    // R9: same pulse left open across the hsync edge, plus an over-long pulse
    clear_field();
    add_pulse(4, 4); add_pulse(4, 4); add_pulse(4, 4); add_pulse(5, 20); add_pulse(5, 4);
    opn[5] = 1'b1;
    run_field("R9 open pulse");
    clear_field();
    add_pulse(3, 4); add_pulse(3, 4); opn[3] = 1'b1; add_pulse(4, 4); add_pulse(5, 4);
    run_field("R9 open mid window");

    // Random fields
    for (int f = 0; f < 30; f++) begin
      int st, ln;
      cfg_ovr      = 1'($urandom_range(0, 1));
      pal_mode     = 1'($urandom_range(0, 1));
      prog_mode    = 1'($urandom_range(0, 1));
      ovs_en       = 1'($urandom_range(0, 1));
      cfg_need_sel = 2'($urandom_range(0, 3));
      cfg_wmin     = 4'($urandom_range(2, 8));
      cfg_wmax     = 4'(int'(cfg_wmin) + $urandom_range(0, 5));
      st           = $urandom_range(1, 20);
      cfg_start    = 6'(st);
      cfg_end      = 6'(st + $urandom_range(0, 12));
      ln = cfg_ovr ? int'(cfg_end) : (pal_mode ? 16 : 21);
      clear_field();
      for (int l = 0; l <= ln; l++) begin
        int n;
        n = $urandom_range(0, 3);
        for (int k = 0; k < n; k++)
          add_pulse(l, (ovs_en ? 2 : 1) * $urandom_range(1, 14) + (ovs_en ? $urandom_range(0, 1) : 0));
        if (n > 0 && $urandom_range(0, 7) == 0) opn[l] = 1'b1;
        else if (n > 0 && $urandom_range(0, 7) == 0) tgt[l] = 1'b1;
      end
      run_field("R1 R3 R6 R7 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule